// File: doc/BRIEF.md
# Stall-Priority Two-Thread Fetch Selector

This block chooses which of two redundant threads, sharing one coarse-grained multithreaded checker core, drives instruction fetch. Each thread has a partner core that runs ahead of it. A partner core can stall, for example when its result buffer toward the checker fills. When that happens, the checker should serve the matching thread first so that the partner can drain and continue.

The selector makes a new choice on each cycle where its select strobe is high. It keeps the current thread and a run-length count. A thread whose partner is stalled takes priority. When both partners are stalled, or neither is, the current thread stays on. The exception is that a thread with no stall is switched out once it has been picked a programmable number of times in a row. This keeps the two threads fair and avoids needless context switches.

Top module: `stall_pick_sel`

## Requirements
- R1: After reset, `fetch_thread` is 0 and the run length is zero.
- R2: On a cycle with `sel_en` low, neither the selected thread nor the run length changes.
- R3: On a strobe with only `stall_t0` high, thread 0 is selected from the next cycle on.
- R4: On a strobe with only `stall_t1` high, thread 1 is selected from the next cycle on.
- R5: On a strobe with both stall flags high, the current thread stays selected.
- R6: On a strobe with neither flag high and the run length below `max_run`, the current thread stays selected.
- R7: On a strobe with neither flag high and the run length at or above `max_run`, the other thread is selected.
- R8: On each strobe, the run length goes up by one if the same thread is picked again. It returns to zero if the pick changes thread.
- R9: The run length saturates at `max_run`. It never wraps, even after long stall-forced runs.
- R10: `max_run` may change at run time. A value of 0 makes every strobe with no stall flag switch threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_en | input | 1 | Select strobe; a new choice is made on cycles where this is high |
| stall_t0 | input | 1 | The partner core of thread 0 is stalled |
| stall_t1 | input | 1 | The partner core of thread 1 is stalled |
| max_run | input | RUN_W | Run-length limit before a forced switch |
| fetch_thread | output | 1 | Thread that currently drives fetch (registered) |

## Verification
The run length is hidden. An error in it shows at `fetch_thread` only on a later strobe with no stall flag, where the keep-or-switch choice depends on it. A count that wraps instead of saturating keeps a thread one or more strobes too long after a long stall-forced run. A count that fails to clear on a switch causes an early switch back. The bench therefore runs long pseudo-random stall and strobe sequences for every small `max_run`. It then drains with all flags low so that each difference in hidden state reaches the output within `max_run + 1` strobes.

// File: rtl/stall_pick_sel.sv
module stall_pick_sel #(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_en,
  input  logic             stall_t0,
  input  logic             stall_t1,
  input  logic [RUN_W-1:0] max_run,
  output logic             fetch_thread
);

  logic             cur_q;
  logic [RUN_W-1:0] run_q;
  logic             pick;
  logic             at_limit;
  logic [RUN_W-1:0] run_next;

  assign at_limit = (run_q >= max_run);

  always_comb begin
    case ({stall_t1, stall_t0})
      2'b01:   pick = 1'b0;
      2'b10:   pick = 1'b1;
      2'b11:   pick = cur_q;
      default: pick = at_limit ? ~cur_q : cur_q;
    endcase
  end

  assign run_next = (pick != cur_q) ? '0 :
                    at_limit        ? max_run :
                                      run_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      run_q <= '0;
    end else if (sel_en) begin
      cur_q <= pick;
      run_q <= run_next;
    end
  end

  assign fetch_thread = cur_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en |=> ($stable(cur_q) && $stable(run_q)));

  // R3
  t0_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && stall_t0 && !stall_t1) |=> (fetch_thread == 1'b0));

  // R4
  t1_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && stall_t1 && !stall_t0) |=> (fetch_thread == 1'b1));

  // R5
  both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && stall_t0 && stall_t1) |=> $stable(fetch_thread));

  // R8
  switch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && (pick != cur_q)) |=> (run_q == '0));

  // R9
  run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_en |=> (run_q <= $past(max_run)));

endmodule

// File: tb/stall_pick_sel_bench.sv
`timescale 1ns/1ps
module stall_pick_sel_bench;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_en = 1'b0;
  logic         st0 = 1'b0;
  logic         st1 = 1'b0;
  logic [W-1:0] max_run = '0;
  logic         fetch_thread;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit exp_cur;
  int exp_run;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  stall_pick_sel #(.RUN_W(W)) u_stall_pick_sel (
    .clk(clk), .rst_n(rst_n), .sel_en(sel_en),
    .stall_t0(st0), .stall_t1(st1), .max_run(max_run),
    .fetch_thread(fetch_thread)
  );

  task automatic check(input string req, input bit exp);
    checks++;
    if (fetch_thread !== exp) begin
      fails++;
      $display("FAIL %s: fetch_thread=%0b expected=%0b", req, fetch_thread, exp);
    end
  endtask

  // Drive at negedge, advance model, check at the following negedge.
  task automatic step(input bit en, input bit s0, input bit s1);
    string tag;
    bit nxt;
    sel_en = en; st0 = s0; st1 = s1;
    tag = "R2";
    nxt = exp_cur;
    if (en) begin
      if (s0 && !s1) begin nxt = 0; tag = "R3"; end
      else if (s1 && !s0) begin nxt = 1; tag = "R4"; end
      else if (s0 && s1) begin nxt = exp_cur; tag = "R5"; end
      else if (exp_run < int'(max_run)) begin nxt = exp_cur; tag = "R6"; end
      else begin nxt = !exp_cur; tag = (max_run == 0) ? "R10" : "R7"; end
      if (nxt != exp_cur) exp_run = 0;
      else if (exp_run >= int'(max_run)) exp_run = int'(max_run);
      else exp_run = exp_run + 1;
      exp_cur = nxt;
    end
    @(negedge clk);
    check(tag, exp_cur);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: expired expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    exp_cur = 0; exp_run = 0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    // R1 run length zero: with max 1, two idle strobes keep then switch
    max_run = 1;
    step(1, 0, 0); // keep, run 1
    step(1, 0, 0); // switch to 1
    step(0, 1, 0); // R2: strobe low, flag ignored
    step(0, 0, 0);
    step(1, 1, 0); // R3
    step(1, 0, 1); // R4
    step(1, 1, 1); // R5

    // R9 saturation: long forced run on thread 0 beyond counter wrap
    max_run = 2;
    for (int i = 0; i < 10; i++) step(1, 1, 0);
    step(1, 0, 0); // R9: must switch at once (wrapped count would keep)
    // R8: after switch count is zero, so two keeps before next switch
    step(1, 0, 0);
    step(1, 0, 0);
    step(1, 0, 0);

    // R10: max 0 alternates each idle strobe
    max_run = 0;
    for (int i = 0; i < 4; i++) step(1, 0, 0);

    // Sweep every limit with pseudo-random stimulus, then drain
    for (int m = 0; m < (1 << W); m++) begin
      max_run = W'(m);
      for (int k = 0; k < 600; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[4] & lfsr[5]);
      end
      for (int k = 0; k < 2 * m + 4; k++) step(1, 0, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule